// File: doc/BRIEF.md
# Programmable Card Clock Generator

This block derives the clock sent to a memory card from a reference clock. A 10-bit ratio code sets the division. Codes from 2 upward divide the reference frequency by the code value. Codes 0 and 1 pass the reference through undivided. An internal enable starts and stops the divider completely, which gives a very low power state. A separate card enable decides whether the divided clock reaches the card pin. An idle request can also stop both clocks while their enables stay set.

After the internal enable rises, or after an accepted ratio write, a stable flag goes low. It rises again once the divider has completed a fixed number of output periods. Software may change the ratio only while the card clock is switched off. The `ratio_ok_o` output reports when that is the case. The card gate opens and closes only while the divided clock is low, so the card pin never sees a shortened pulse.

Top module: `ckg_card_clock`

## Requirements
- R1: For a ratio code N with 2 <= N <= 1023, the card clock, sampled once per reference cycle, repeats every N reference cycles. It is high for floor(N/2) of those cycles.
- R2: Ratio codes 0 and 1 both bypass the divider. While the gate is open, the card clock equals the reference clock.
- R3: While `int_en_i` is 0, the divider is stopped and cleared. The card clock is 0 on both reference phases, and `stable_o` is 0.
- R4: `stable_o` is 0 in the cycle after an accepted ratio write or while `int_en_i` is low. Counting reference edges from the write edge, or from the first edge at which the enable is seen high, `stable_o` first reads 1 after edge 4*max(N,1).
- R5: The card clock is 0 whenever the card gate is closed. With `card_en_i` at 0, the card clock stays 0.
- R6: `ratio_ok_o` is 1 only while `card_en_i` is 0 and the card gate is closed. A ratio write made while `ratio_ok_o` is 0 is ignored: the old division stays in force and `stable_o` stays 1.
- R7: While `idle_i` is 1, the divider holds its state and the card clock makes no transitions. `stable_o` keeps its value.
- R8: The card gate changes state only at a falling reference edge, and only when the divided clock is low or the divider is bypassed.
- R9: After reset the ratio code is 0 (bypass), the card clock is 0 and `stable_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 10 | New division ratio code |
| ratio_we_i | input | 1 | Ratio write strobe |
| int_en_i | input | 1 | Internal clock enable |
| card_en_i | input | 1 | Card clock enable |
| idle_i | input | 1 | Idle request; gates both clocks |
| card_clk_o | output | 1 | Clock to the card |
| stable_o | output | 1 | Internal clock has settled |
| ratio_ok_o | output | 1 | Ratio may be written now |

## Verification
The bound checker watches several rules on every cycle. The stable flag must drop after an accepted write or a disable. The ratio must not move while writes are refused. The card output must be silent while the gate is shut. The gate must switch only at a falling edge with the divided clock low.

Other behaviour spans many cycles and needs the bench scenarios to show it. This covers the exact period and high time for each code, bypass mode tracking the reference on both phases, the exact cycle at which the stable flag returns, and the frozen output during idle. The bench sweeps codes 0 to 12 and 1023 and works out each expected waveform arithmetically.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
   // Codes below two select pass-through of the reference clock.
   function automatic logic ckg_is_bypass(input logic [9:0] code);
      return (code < 10'd2);
   endfunction
endpackage

// File: rtl/ckg_divider.sv
module ckg_divider #(
   parameter int RATIO_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               run,
   input  logic               bypass,
   input  logic [RATIO_W-1:0] ratio,
   output logic               div_q,
   output logic               tick
);
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] cnt_nxt;
   logic [RATIO_W-1:0] hi_len;

   assign hi_len  = ratio >> 1;
   assign cnt_nxt = (cnt_q == ratio - RATIO_W'(1)) ? '0 : cnt_q + RATIO_W'(1);
   // one pulse per output period, at the divided clock's rising edge
   assign tick    = run & (bypass | (cnt_nxt == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (run && !bypass) begin
         cnt_q <= cnt_nxt;
         div_q <= (cnt_nxt < hi_len);
      end
   end
endmodule

// File: rtl/ckg_stable.sv
module ckg_stable #(
   parameter int PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic stable
);
   localparam int CW = $clog2(PERIODS + 1);
   localparam logic [CW-1:0] LAST = CW'(PERIODS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr)                    cnt_q <= '0;
      else if (tick && cnt_q != LAST)  cnt_q <= cnt_q + CW'(1);
   end

   assign stable = (cnt_q == LAST);
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic safe,
   output logic gate_q
);
   // Sampled on the falling edge: the reference is low then, and the
   // divided clock only moves on rising edges.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)     gate_q <= 1'b0;
      else if (safe)  gate_q <= want;
   end
endmodule

// File: rtl/ckg_card_clock.sv
module ckg_card_clock #(
   parameter int RATIO_W        = 10,
   parameter int STABLE_PERIODS = 4
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               ratio_we_i,
   input  logic               int_en_i,
   input  logic               card_en_i,
   input  logic               idle_i,
   output logic               card_clk_o,
   output logic               stable_o,
   output logic               ratio_ok_o
);
   import ckg_pkg::*;

   if (RATIO_W != 10) begin : g_bad_width
      $error("ckg_card_clock: RATIO_W must be 10");
   end
   if (STABLE_PERIODS < 1) begin : g_bad_periods
      $error("ckg_card_clock: STABLE_PERIODS must be at least 1");
   end

   logic [RATIO_W-1:0] ratio_q;
   logic               wr_acc;
   logic               bypass;
   logic               run;
   logic               clr;
   logic               div_q;
   logic               tick;
   logic               gate_q;

   assign ratio_ok_o = ~card_en_i & ~gate_q;
   assign wr_acc     = ratio_we_i & ratio_ok_o;
   assign bypass     = ckg_is_bypass(ratio_q);
   assign run        = int_en_i & ~idle_i;
   assign clr        = ~int_en_i | wr_acc;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)       ratio_q <= '0;
      else if (wr_acc)  ratio_q <= ratio_i;
   end

   ckg_divider #(.RATIO_W(RATIO_W)) u_div (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .run    (run),
      .bypass (bypass),
      .ratio  (ratio_q),
      .div_q  (div_q),
      .tick   (tick)
   );

   ckg_stable #(.PERIODS(STABLE_PERIODS)) u_stab (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .tick   (tick),
      .stable (stable_o)
   );

   ckg_gate u_gate (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .want   (card_en_i & run),
      .safe   (bypass | ~div_q),
      .gate_q (gate_q)
   );

   assign card_clk_o = gate_q & (bypass ? ref_clk : div_q);
endmodule

// File: rtl/ckg_card_clock_chk.sv
module ckg_card_clock_chk #(
   parameter int RATIO_W = 10
) (
   input logic               ref_clk,
   input logic               rst_n,
   input logic               ratio_we_i,
   input logic               int_en_i,
   input logic               ratio_ok_o,
   input logic               stable_o,
   input logic               card_clk_o,
   input logic [RATIO_W-1:0] ratio_q,
   input logic               gate_q,
   input logic               div_q,
   input logic               bypass
);
   a_r3_off_unstable: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !int_en_i |=> !stable_o);

   a_r4_write_drops_stable: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (ratio_we_i && ratio_ok_o) |=> !stable_o);

   a_r6_ratio_held: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !ratio_ok_o |=> $stable(ratio_q));

   a_r5_gate_closed_silent: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !gate_q |-> !card_clk_o);

   a_r8_gate_safe: assert property (@(negedge ref_clk) disable iff (!rst_n)
      (gate_q != $past(gate_q)) |-> ($past(bypass) || !$past(div_q)));
endmodule

bind ckg_card_clock ckg_card_clock_chk #(.RATIO_W(RATIO_W)) u_chk (
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .ratio_we_i (ratio_we_i),
   .int_en_i   (int_en_i),
   .ratio_ok_o (ratio_ok_o),
   .stable_o   (stable_o),
   .card_clk_o (card_clk_o),
   .ratio_q    (ratio_q),
   .gate_q     (gate_q),
   .div_q      (div_q),
   .bypass     (bypass)
);

// File: tb/sim_ckg_card_clock.sv
module sim_ckg_card_clock;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] ratio = '0;
   logic       we = 1'b0;
   logic       int_en = 1'b0;
   logic       card_en = 1'b0;
   logic       idle = 1'b0;
   logic       card_clk;
   logic       stable;
   logic       ratio_ok;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   ckg_card_clock u0 (
      .ref_clk(clk), .rst_n(rst_n), .ratio_i(ratio), .ratio_we_i(we),
      .int_en_i(int_en), .card_en_i(card_en), .idle_i(idle),
      .card_clk_o(card_clk), .stable_o(stable), .ratio_ok_o(ratio_ok)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic close_card();
      @(negedge clk);
      card_en = 1'b0;
      for (int i = 0; i < 3000 && !ratio_ok; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // write code n, then check the stable flag returns on edge 4*max(n,1)
   task automatic write_ratio(input int n, input string req);
      int neff = (n < 2) ? 1 : n;
      int first = -1;
      @(negedge clk);
      ratio = 10'(n);
      we = 1'b1;
      @(posedge clk);
      #5;
      we = 1'b0;
      chk({req, " R4 stable drop"}, int'(stable), 0);
      for (int k = 1; k <= 4 * neff + 1; k++) begin
         @(posedge clk);
         #5;
         if (stable && first < 0) first = k;
      end
      chk({req, " R4 stable edge"}, first, 4 * neff);
   endtask

   // sample 2n cycles of divided output: period n, high floor(n/2)
   task automatic measure_div(input int n, input string req);
      logic s[2048];
      int highs = 0;
      int bad = 0;
      for (int i = 0; i < 2 * n; i++) begin
         @(posedge clk);
         #5;
         s[i] = card_clk;
      end
      for (int i = 0; i < n; i++) begin
         if (s[i]) highs++;
         if (s[i] != s[i + n]) bad++;
      end
      chk({req, " R1 high time"}, highs, n / 2);
      chk({req, " R1 period"}, bad, 0);
   endtask

   task automatic measure_bypass(input string req);
      int bad = 0;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #5; if (card_clk !== 1'b1) bad++;
         @(negedge clk); #5; if (card_clk !== 1'b0) bad++;
      end
      chk({req, " R2 follows reference"}, bad, 0);
   endtask

   task automatic open_card(input int n);
      @(negedge clk);
      card_en = 1'b1;
      for (int i = 0; i < 2 * n + 3; i++) @(posedge clk);
   endtask

   initial begin
      int codes[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 1023};
      int hold;
      #35;
      // R9 reset state, bypass code after reset
      chk("R9 stable", int'(stable), 0);
      chk("R9 card clock", int'(card_clk), 0);
      chk("R6 ratio_ok idle", int'(ratio_ok), 1);
      rst_n = 1'b1;
      @(negedge clk);
      int_en = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(posedge clk); #5;
         if (k == 3) chk("R4 R9 stable before 4 edges", int'(stable), 0);
      end
      chk("R4 R9 stable after enable", int'(stable), 1);
      open_card(1);
      measure_bypass("R9 reset code");
      close_card();

      foreach (codes[j]) begin
         write_ratio(codes[j], $sformatf("code %0d", codes[j]));
         open_card(codes[j]);
         chk("R6 ratio_ok with card on", int'(ratio_ok), 0);
         if (codes[j] < 2) measure_bypass($sformatf("code %0d", codes[j]));
         else measure_div(codes[j], $sformatf("code %0d", codes[j]));
         close_card();
      end

      // R5: card enable low keeps output silent
      write_ratio(5, "setup");
      hold = 0;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk); #5; if (card_clk) hold++;
      end
      chk("R5 card off silent", hold, 0);

      // R6: write refused while card runs
      open_card(5);
      @(negedge clk);
      ratio = 10'd3;
      we = 1'b1;
      @(posedge clk); #5;
      we = 1'b0;
      chk("R6 stable kept on refused write", int'(stable), 1);
      measure_div(5, "R6 old ratio kept");

      // R7: idle freezes the card clock
      @(negedge clk);
      idle = 1'b1;
      @(posedge clk); #5;
      hold = int'(card_clk);
      begin
         int moved = 0;
         for (int i = 0; i < 10; i++) begin
            @(posedge clk); #5; if (int'(card_clk) != hold) moved++;
            @(negedge clk); #5; if (int'(card_clk) != hold) moved++;
         end
         chk("R7 idle no transitions", moved, 0);
      end
      chk("R7 stable held in idle", int'(stable), 1);
      @(negedge clk);
      idle = 1'b0;
      for (int i = 0; i < 12; i++) @(posedge clk);
      measure_div(5, "R7 resume");

      // R3: internal enable low stops everything
      @(negedge clk);
      int_en = 1'b0;
      @(posedge clk); #5;
      chk("R3 R4 stable drops", int'(stable), 0);
      begin
         int hi = 0;
         for (int i = 0; i < 12; i++) begin
            @(posedge clk); #5; if (card_clk) hi++;
            @(negedge clk); #5; if (card_clk) hi++;
         end
         chk("R3 card clock off", hi, 0);
      end
      chk("R3 stable off", int'(stable), 0);
      @(negedge clk);
      int_en = 1'b1;
      begin
         int first = -1;
         for (int k = 1; k <= 21; k++) begin
            @(posedge clk); #5;
            if (stable && first < 0) first = k;
         end
         chk("R4 requalify after enable", first, 20);
      end
      measure_div(5, "R3 restart");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule